// File: doc/BRIEF.md
# Rotating Virtual-to-Real Gate Mapper

The block sits between a converter arm's modulator and its power cells. The modulator produces one gate bit per virtual cell. The mapper sends each of those bits to a real cell through a rotating offset. Over one full turn of the offset, every real cell carries the duty of every virtual cell. As a result, each real cell switches with the same long-run pattern, and their capacitor voltages stay together.

The offset is a slow count-up index. It advances once for every `DIVIDE` cycles in which the rotation enable is high. The internal prescaler turns the enable into a strobe at the wanted rotation rate. If the enable is itself a strobe at that rate, set `DIVIDE` to 1.

The gate outputs are registered. They load only on cycles in which the virtual vector is flagged valid. Reset clears the index, which gives the identity mapping. Reset also drives every real gate OFF until the first valid vector arrives.

Top module: `cell_rotor`

## Requirements
- R1: While reset is asserted, and after its release until the next clock edge, `idx_o` is 0 and every bit of `rgate_o` is 0 (OFF). This holds whatever the inputs are doing.
- R2: One clock after a cycle with `vgate_valid_i` high, `rgate_o[k]` equals `vgate_i[(k + m) mod N]` from that cycle. Here m is the value `idx_o` showed in that cycle.
- R3: After a cycle with `vgate_valid_i` low, `rgate_o` keeps its previous value, whatever `vgate_i` carried.
- R4: `idx_o` advances by exactly one, from N-1 back to 0, at the clock edge that ends the `DIVIDE`-th cycle of `step_en_i` high since the previous advance (or since reset). At no other edge does it change.
- R5: Cycles with `step_en_i` low neither advance `idx_o` nor count toward the next advance.
- R6: A gate vector presented in the same cycle as an advancing step is still mapped with the old index. The new index applies from the following vector on.
- R7: Present a one-hot virtual vector at each of the N index values. Then every real cell has carried each virtual cell exactly once.
- R8: For a fixed virtual vector, real cell k+1 under index m shows the same gate as real cell k under index m+1 (indices mod N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Rotation enable; its high cycles are counted by the prescaler |
| vgate_valid_i | input | 1 | Qualifies `vgate_i` for loading |
| vgate_i | input | N | Gate bits of the virtual cells, 1 = inserted |
| rgate_o | output | N | Gate bits of the real cells, 1 = inserted |
| idx_o | output | clog2(N) | Current rotation offset |

## Verification
The hardest condition to reach from the ports is the cycle in which a step completes while a new vector is loaded. In that cycle the index register and the gate register change on the same edge. The test drives valid vectors through every enable cycle of each prescaler period, so the advancing cycle always carries a fresh vector whose mapping must still use the old offset. It also spaces the enable with idle cycles, which confirms that the prescaler keeps its partial count.

// File: rtl/cell_rotor.sv
module cell_rotor #(
  parameter int N      = 4,
  parameter int DIVIDE = 3,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int PW    = (DIVIDE > 1) ? $clog2(DIVIDE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en_i,
  input  logic          vgate_valid_i,
  input  logic [N-1:0]  vgate_i,
  output logic [N-1:0]  rgate_o,
  output logic [IW-1:0] idx_o
);

  logic          strobe;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  rgate_q;
  logic [N-1:0]  mapped;

  generate
    if (DIVIDE > 1) begin : g_div
      logic [PW-1:0] pcnt_q;
      assign strobe = step_en_i && (pcnt_q == PW'(DIVIDE - 1));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)         pcnt_q <= '0;
        else if (step_en_i) pcnt_q <= strobe ? '0 : pcnt_q + 1'b1;
    end else begin : g_nodiv
      assign strobe = step_en_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      idx_q <= '0;
    else if (strobe) idx_q <= (idx_q == IW'(N - 1)) ? '0 : idx_q + 1'b1;

  always_comb
    for (int k = 0; k < N; k++) begin
      int s;
      s = k + int'(idx_q);
      if (s >= N) s = s - N;
      mapped[k] = vgate_i[s];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             rgate_q <= '0;
    else if (vgate_valid_i) rgate_q <= mapped;

  assign rgate_o = rgate_q;
  assign idx_o   = idx_q;

  logic live_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (idx_o == '0 && rgate_o == '0));

  a_r2_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(vgate_valid_i) |-> $countones(rgate_o) == $countones($past(vgate_i)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !$past(vgate_valid_i) |-> $stable(rgate_o));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !$stable(idx_o) |->
      int'(idx_o) == ((int'($past(idx_o)) == N - 1) ? 0 : int'($past(idx_o)) + 1));

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_o) < N);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !$past(step_en_i) |-> $stable(idx_o));

endmodule

// File: tb/cell_rotor_test.sv
module cell_rotor_test;
  localparam int N = 4;
  localparam int DIVIDE = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en_i = 1'b0;
  logic vgate_valid_i = 1'b0;
  logic [N-1:0] vgate_i = '0;
  logic [N-1:0] rgate_o;
  logic [IW-1:0] idx_o;

  int checks = 0, failures = 0;
  int exp_idx = 0, exp_pc = 0;
  logic [N-1:0] exp_rg = '0;
  int seen [N][N];
  logic [N-1:0] trace [N];

  always #4 clk = ~clk;

  cell_rotor #(.N(N), .DIVIDE(DIVIDE)) uut (
    .clk(clk), .rst_n(rst_n), .step_en_i(step_en_i),
    .vgate_valid_i(vgate_valid_i), .vgate_i(vgate_i),
    .rgate_o(rgate_o), .idx_o(idx_o));

  function automatic logic [N-1:0] map_of(logic [N-1:0] v, int m);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = v[(k + m) % N];
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic st, logic vl, logic [N-1:0] vg);
    step_en_i = st; vgate_valid_i = vl; vgate_i = vg;
    @(posedge clk);
    if (vl) exp_rg = map_of(vg, exp_idx);
    if (st) begin
      if (exp_pc == DIVIDE - 1) begin exp_pc = 0; exp_idx = (exp_idx + 1) % N; end
      else exp_pc++;
    end
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    step_en_i = 1'b1; vgate_valid_i = 1'b1; vgate_i = '1;
    repeat (3) @(negedge clk);
    check("R1 idx in reset", int'(idx_o), 0);
    check("R1 gates in reset", int'(rgate_o), 0);
    rst_n = 1'b1;
    check("R1 idx after release", int'(idx_o), 0);
    check("R1 gates after release", int'(rgate_o), 0);

    for (int r = 0; r < N; r++) begin
      for (int v = 0; v < (1 << N); v++) begin
        cyc(1'b0, 1'b1, N'(v));
        check("R2 mapping", int'(rgate_o), int'(exp_rg));
      end
      for (int s = 0; s < DIVIDE; s++) begin
        logic [N-1:0] pat;
        pat = N'((r * 5 + s * 3 + 1) % (1 << N));
        cyc(1'b1, 1'b1, pat);
        check("R6 old index on step cycle", int'(rgate_o), int'(exp_rg));
        check("R4 index at step", int'(idx_o), exp_idx);
      end
    end
    check("R4 wrapped to zero", int'(idx_o), 0);

    cyc(1'b0, 1'b1, 4'b1010);
    for (int v = 0; v < 8; v++) begin
      cyc(1'b0, 1'b0, N'(v * 7));
      check("R3 hold when not valid", int'(rgate_o), int'(exp_rg));
    end

    for (int s = 0; s < 2 * DIVIDE * N; s++) begin
      cyc(1'b1, 1'b0, '0);
      for (int g = 0; g < s % 3; g++) begin
        cyc(1'b0, 1'b0, '1);
        check("R5 idle keeps index", int'(idx_o), exp_idx);
      end
      check("R4 step count", int'(idx_o), exp_idx);
    end

    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) seen[a][b] = 0;
    for (int r = 0; r < N; r++) begin
      for (int v = 0; v < N; v++) begin
        cyc(1'b0, 1'b1, N'(1 << v));
        check("R7 one-hot kept", $countones(rgate_o), 1);
        for (int k = 0; k < N; k++) if (rgate_o[k]) seen[k][v]++;
      end
      cyc(1'b0, 1'b1, 4'b1011);
      trace[exp_idx] = rgate_o;
      for (int s = 0; s < DIVIDE; s++) cyc(1'b1, 1'b0, '0);
    end
    for (int k = 0; k < N; k++)
      for (int v = 0; v < N; v++)
        check("R7 each virtual cell once per real cell", seen[k][v], 1);

    for (int m = 0; m < N; m++)
      for (int k = 0; k < N; k++)
        check("R8 neighbour shifted by one step",
              int'(trace[m][(k + 1) % N]), int'(trace[(m + 1) % N][k]));

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 idx on re-reset", int'(idx_o), 0);
    check("R1 gates on re-reset", int'(rgate_o), 0);

    finish_up();
  end
endmodule